// File: doc/BRIEF.md
# Dual-Read General-Purpose Register File with Marker Reset

This block holds the architectural integer registers of a 64-bit processor core: thirty-two words of 64 bits, selected by 5-bit identifiers. Two read ports return stored words combinationally, so a decode stage can fetch both source operands in the cycle it presents their identifiers. A single write port commits a result on the rising clock edge.

Identifier 0 is a constant zero source and silently drops anything written to it. A synchronous, active-low reset places the file in a known state. The four pointer registers for stack, frame, thread data and global data, at identifiers 7 through 10, start at zero. Every other writable register starts at the recognisable marker word 0x1A1A1A1A1A1A1A1A, so that a read of a register software never initialised stands out in a trace.

Top module: `regfile_top`

## Requirements
- R1: The file holds 32 words of 64 bits, and the two read ports select entries independently through their own 5-bit identifiers (0 to 31).
- R2: Identifier 0 always reads as all zeros on both ports, and a write addressed to it changes nothing.
- R3: After a reset cycle, every identifier other than 0 and 7 to 10 reads 64'h1A1A1A1A1A1A1A1A.
- R4: After a reset cycle, identifiers 7, 8, 9 and 10 read as zero.
- R5: Reset is active low and synchronous: it takes effect only at a rising edge where rst_n is 0, and stored contents persist while rst_n stays 1.
- R6: With wr_en high at a rising edge, wr_data is stored at wr_addr and is visible from the next cycle; with wr_en low nothing changes.
- R7: Reads are combinational, and a read of the entry being written in the same cycle returns the value held before that edge.
- R8: When rst_n is 0 and wr_en is 1 at the same edge, the reset value wins over the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 5 | Register identifier for read port A |
| rd_addr_b | input | 5 | Register identifier for read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register identifier to write |
| wr_data | input | 64 | Word to write |
| rd_data_a | output | 64 | Word at rd_addr_a |
| rd_data_b | output | 64 | Word at rd_addr_b |

## Verification
Read data depends on the current identifiers with no register in the path, so each read is due in the same cycle its address is applied, while a write or a reset only becomes visible one rising edge later. The bench applies every stimulus just after a falling edge and samples the read ports a short delay later, still before the next rising edge, so a same-cycle read shows pre-edge contents. A behavioural reference array is updated only after each rising edge, giving the exact one-edge lag for writes and resets, and both ports are compared against it in every checked cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_DATA_W   = 64;
    localparam int RF_NUM_REGS = 32;
    localparam int RF_ADDR_W   = $clog2(RF_NUM_REGS);

    // Byte repeated across a word to mark registers never written since reset
    localparam logic [7:0] MARKER_BYTE = 8'h1A;

    // Range of pointer registers that clear to zero on reset
    localparam int PTR_FIRST_ID = 7;
    localparam int PTR_LAST_ID  = 10;

    typedef enum logic [1:0] {
        ROLE_ZERO    = 2'd0,
        ROLE_POINTER = 2'd1,
        ROLE_GENERAL = 2'd2
    } rf_role_e;

    function automatic rf_role_e role_of(input int id);
        if (id == 0)
            return ROLE_ZERO;
        else if (id >= PTR_FIRST_ID && id <= PTR_LAST_ID)
            return ROLE_POINTER;
        else
            return ROLE_GENERAL;
    endfunction

    function automatic logic [RF_DATA_W-1:0] marker_word();
        return {(RF_DATA_W/8){MARKER_BYTE}};
    endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NUM_REGS-1:0] entry_we
);
    import rf_pkg::*;

    // One-hot enable per entry; the zero entry never gets one
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        if (role_of(i) == ROLE_ZERO) begin : g_zero
            assign entry_we[i] = 1'b0;
        end else begin : g_live
            assign entry_we[i] = wr_en && (wr_addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            entry_we,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0] entries
);
    import rf_pkg::*;

    localparam logic [DATA_W-1:0] MARKER = {(DATA_W/8){MARKER_BYTE}};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        if (role_of(i) == ROLE_ZERO) begin : g_const
            assign entries[i] = '0;
        end else begin : g_reg
            localparam logic [DATA_W-1:0] RST_VAL =
                (role_of(i) == ROLE_POINTER) ? '0 : MARKER;
            logic [DATA_W-1:0] q;
            // Reset outranks a write arriving at the same edge
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RST_VAL;
                else if (entry_we[i])
                    q <= wr_data;
            end
            assign entries[i] = q;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] entries,
    input  logic [ADDR_W-1:0]               addr,
    output logic [DATA_W-1:0]               data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i))
                data = entries[i];
        end
    end

endmodule

// File: rtl/regfile_top.sv
module regfile_top #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0]             entry_we;
    logic [NUM_REGS-1:0][DATA_W-1:0] entries;
    logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];

    rf_write_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .entry_we (entry_we)
    );

    rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .entry_we (entry_we),
        .wr_data  (wr_data),
        .entries  (entries)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_port (
            .entries (entries),
            .addr    (rd_addr[p]),
            .data    (rd_data[p])
        );
    end

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ADDR_W = rf_pkg::RF_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    import rf_pkg::*;

    localparam logic [DATA_W-1:0] MARK = {(DATA_W/8){MARKER_BYTE}};

    assert_zero_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    assert_ptr_reset_R4: assert property (@(posedge clk)
        !rst_n |=> (role_of(int'(rd_addr_a)) != ROLE_POINTER || rd_data_a == '0));

    assert_marker_reset_R3: assert property (@(posedge clk)
        !rst_n |=> (role_of(int'(rd_addr_b)) != ROLE_GENERAL || rd_data_b == MARK));

    assert_reset_beats_write_R8: assert property (@(posedge clk)
        (!rst_n && wr_en) |=> (rd_addr_a != $past(wr_addr)
                               || role_of(int'(rd_addr_a)) != ROLE_GENERAL
                               || rd_data_a == MARK));

    assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == rd_addr_a) |=> (!$stable(rd_addr_a) || $stable(rd_data_a)));

endmodule

bind regfile_top rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/sim_regfile_top.sv
`timescale 1ns/1ps
module sim_regfile_top;

    localparam logic [63:0] MARK = 64'h1A1A1A1A1A1A1A1A;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic        wr_en;
    logic [63:0] wr_data;
    logic [63:0] rd_data_a, rd_data_b;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [63:0] model [32];

    always #10 clk = ~clk;

    regfile_top u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    task automatic check(string req, string port, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %s: actual %h expected %h", req, port, act, exp);
        end
    endtask

    function automatic string reset_tag(int id);
        if (id == 0) return "R2";
        if (id >= 7 && id <= 10) return "R4";
        return "R3";
    endfunction

    // One clock: drive after a falling edge, sample before the rising edge,
    // then advance the reference model past the edge.
    task automatic step(bit rn, bit we, int wa, logic [63:0] wd,
                        int a, int b, string tag_a, string tag_b, bit chk);
        rst_n = rn; wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        rd_addr_a = 5'(a); rd_addr_b = 5'(b);
        #2;
        if (chk) begin
            check(tag_a, "A", rd_data_a, model[a]);
            check(tag_b, "B", rd_data_b, model[b]);
        end
        @(posedge clk);
        if (!rn) begin
            for (int i = 0; i < 32; i++)
                model[i] = (i == 0 || (i >= 7 && i <= 10)) ? 64'h0 : MARK;
        end else if (we && wa != 0) begin
            model[wa] = wd;
        end
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        for (int i = 0; i < 32; i++) model[i] = 'x;
        @(negedge clk);

        // Reset and scan every entry on both ports (R3, R4, R2)
        step(0, 0, 0, 0, 0, 0, "R5", "R5", 0);
        for (int i = 0; i < 16; i++)
            step(1, 0, 0, 0, i, i + 16, reset_tag(i), reset_tag(i + 16), 1);

        // Writes with same-cycle old-value read (R7) and next-cycle readback (R6)
        step(1, 1, 3, 64'hDEAD_BEEF_0123_4567, 3, 0, "R7", "R2", 1);
        step(1, 1, 8, 64'hFFFF_FFFF_FFFF_FFFF, 8, 3, "R7", "R6", 1);
        step(1, 1, 31, 64'h8000_0000_0000_0001, 31, 8, "R7", "R6", 1);
        step(1, 0, 0, 0, 31, 3, "R6", "R1", 1);

        // Write enable low leaves the entry unchanged (R6)
        step(1, 0, 3, 64'h1111_2222_3333_4444, 3, 3, "R7", "R6", 1);
        step(1, 0, 0, 0, 3, 31, "R6", "R1", 1);

        // Write to identifier 0 is dropped (R2)
        step(1, 1, 0, 64'hCAFE_CAFE_CAFE_CAFE, 0, 0, "R2", "R2", 1);
        step(1, 0, 0, 0, 0, 0, "R2", "R2", 1);

        // Independent port selection across a spread of entries (R1)
        step(1, 1, 12, 64'h0000_0000_0000_0C0C, 12, 13, "R7", "R1", 1);
        step(1, 1, 13, 64'h0000_0000_0000_0D0D, 12, 13, "R1", "R7", 1);
        step(1, 0, 0, 0, 13, 12, "R1", "R1", 1);

        // Contents persist while rst_n stays high (R5)
        for (int k = 0; k < 3; k++)
            step(1, 0, 0, 0, 8, 31, "R5", "R5", 1);

        // Reset low: during the reset cycle old data still shows (R5),
        // and the simultaneous write to 5 loses to reset (R8)
        step(0, 1, 5, 64'h5555_5555_5555_5555, 8, 5, "R5", "R5", 1);
        step(1, 0, 0, 0, 5, 8, "R8", "R4", 1);
        step(1, 0, 0, 0, 3, 31, "R3", "R3", 1);

        // Reset against a write to a pointer entry (R8)
        step(1, 1, 9, 64'h9999_0000_9999_0000, 9, 9, "R7", "R7", 1);
        step(0, 1, 9, 64'h1234_5678_9ABC_DEF0, 9, 10, "R5", "R4", 1);
        step(1, 0, 0, 0, 9, 7, "R8", "R4", 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule